// File: doc/BRIEF.md
# Strided Vector Load Sequencer

The sequencer turns one vector load instruction into a run of single-element memory reads. The instruction names a destination register N, a base register M, an immediate offset and an element count. For element i the sequencer reads register M+i through its register-read port and forms a memory address from that value. It issues one memory request and waits for the response. It then writes the returned word to register N+i through its register-write port, and moves on to the next element.

The element offset and the stride come from a small table of offset entries. Each entry holds an enable bit, a register field, an offset amount and a stride-mode bit. The table is scanned in ascending entry order, and the first enabled entry whose register field equals M applies. When no entry applies, the offset is zero and the stride is one. The element count is the vector-length setting that belongs to register N; the caller presents it with the start pulse.

Top module: `svl_sequencer`

## Requirements
- R1: While reset is asserted, and right after it, busy, done, mem_req_valid and wr_en are all low.
- R2: When no enabled table entry has a register field equal to M, the offset is 0 and the stride is 1. Disabled entries never match.
- R3: Entries are scanned in ascending order (entry 0 first). The first enabled entry whose register field equals M supplies the offset amount, and later matching entries are ignored.
- R4: In the matching entry, a stride-mode bit of 1 makes the stride equal the start immediate. A stride-mode bit of 0 keeps the stride at 1.
- R5: The memory address of element i is (offset × i + r[M+i]) × stride, taken modulo 2^AW.
- R6: The response for element i is written to register N+i, in ascending i, exactly start_len times. Register indices wrap modulo the register count.
- R7: At most one memory request is outstanding. A new request is raised only after the previous response has been written back. A request that is not accepted keeps mem_req_valid high and its address unchanged.
- R8: done is high for exactly one cycle, in the cycle after the last write. busy is high from the cycle after an accepted start through the done cycle.
- R9: A start with start_len = 0 makes no memory request and no write, and raises done in the cycle after start.
- R10: A start pulse while busy is high is ignored. The running operation keeps its registers and its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| start_dst | input | RW | Destination register N |
| start_base | input | RW | Base register M |
| start_imm | input | AW | Immediate load offset, used as stride in offset mode |
| start_len | input | LEN_W | Element count (vector-length setting of N) |
| ofs_en | input | NUM_OFS | Per-entry enable of the offset table |
| ofs_reg | input | NUM_OFS*RW | Per-entry register field, entry k at bits k*RW |
| ofs_amt | input | NUM_OFS*AW | Per-entry offset amount, entry k at bits k*AW |
| ofs_imm_stride | input | NUM_OFS | Per-entry stride mode: 1 = stride from immediate |
| rd_addr | output | RW | Register-read index (M+i) |
| rd_data | input | DW | Register-read data, combinational |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | AW | Memory request address |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_data | input | DW | Memory response data |
| wr_en | output | 1 | Register-write enable |
| wr_addr | output | RW | Register-write index (N+i) |
| wr_data | output | DW | Register-write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The first request rises in the cycle after an accepted start. Each register write happens in the same cycle as its memory response. done follows one cycle after the last write, or one cycle after start when the count is zero. The bench drives inputs and samples outputs on the falling edge. It logs every accepted request and every write at the rising edge, so each request address and each write is compared in order, independently of the memory latency and ready stalls. The done pulse and busy are sampled at the exact falling edges that these cycle counts predict.

// File: rtl/svl_pkg.sv
package svl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } svl_state_e;

  // element address: (offset * index + base value) * stride, callers truncate
  function automatic logic [63:0] svl_elem_addr(input logic [63:0] ofs,
                                                input logic [63:0] idx,
                                                input logic [63:0] base,
                                                input logic [63:0] stride);
    return (ofs * idx + base) * stride;
  endfunction

  // an offset entry applies when enabled and its register field names the base
  function automatic logic svl_entry_hit(input logic        en,
                                         input logic [63:0] ent_reg,
                                         input logic [63:0] base_reg);
    return en && (ent_reg == base_reg);
  endfunction

  // register index after stepping by the element number, wrapping naturally
  function automatic logic [63:0] svl_reg_step(input logic [63:0] first,
                                               input logic [63:0] idx);
    return first + idx;
  endfunction

endpackage

// File: rtl/svl_ofs_lookup.sv
module svl_ofs_lookup #(
  parameter int NUM_OFS = 2,
  parameter int RW      = 5,
  parameter int AW      = 32
) (
  input  logic [RW-1:0]         base_reg_i,
  input  logic [AW-1:0]         imm_i,
  input  logic [NUM_OFS-1:0]    ent_en_i,
  input  logic [NUM_OFS*RW-1:0] ent_reg_i,
  input  logic [NUM_OFS*AW-1:0] ent_amt_i,
  input  logic [NUM_OFS-1:0]    ent_imm_stride_i,
  output logic [AW-1:0]         ofs_o,
  output logic [AW-1:0]         stride_o
);

  logic [NUM_OFS-1:0] match;
  logic [AW-1:0]      ofs_ch [NUM_OFS+1];
  logic [AW-1:0]      str_ch [NUM_OFS+1];

  // fall-through values when no entry applies
  assign ofs_ch[NUM_OFS] = '0;
  assign str_ch[NUM_OFS] = AW'(1);

  // priority chain: a lower entry overrides everything above it
  for (genvar g = 0; g < NUM_OFS; g++) begin : g_ent
    assign match[g]  = svl_pkg::svl_entry_hit(ent_en_i[g],
                                              64'(ent_reg_i[g*RW +: RW]),
                                              64'(base_reg_i));
    assign ofs_ch[g] = match[g] ? ent_amt_i[g*AW +: AW] : ofs_ch[g+1];
    assign str_ch[g] = match[g] ? (ent_imm_stride_i[g] ? imm_i : AW'(1))
                                : str_ch[g+1];
  end

  assign ofs_o    = ofs_ch[0];
  assign stride_o = str_ch[0];

endmodule

// File: rtl/svl_addr_gen.sv
module svl_addr_gen #(
  parameter int AW    = 32,
  parameter int LEN_W = 4
) (
  input  logic [AW-1:0]    ofs_i,
  input  logic [AW-1:0]    stride_i,
  input  logic [LEN_W-1:0] idx_i,
  input  logic [AW-1:0]    base_val_i,
  output logic [AW-1:0]    addr_o
);

  assign addr_o = AW'(svl_pkg::svl_elem_addr(64'(ofs_i), 64'(idx_i),
                                             64'(base_val_i), 64'(stride_i)));

endmodule

// File: rtl/svl_elem_ctrl.sv
module svl_elem_ctrl #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             req_ready_i,
  input  logic             rsp_valid_i,
  output logic             accept_o,
  output logic [LEN_W-1:0] idx_o,
  output logic             req_valid_o,
  output logic             wr_fire_o,
  output logic             last_o,
  output logic             busy_o,
  output logic             done_o
);

  import svl_pkg::*;

  svl_state_e       state_q, state_d;
  logic [LEN_W-1:0] idx_q, idx_d;
  logic [LEN_W-1:0] len_q, len_d;

  assign accept_o    = start_i && (state_q == ST_IDLE);
  assign req_valid_o = (state_q == ST_REQ);
  assign wr_fire_o   = (state_q == ST_WAIT) && rsp_valid_i;
  assign last_o      = (idx_q == len_q - LEN_W'(1));
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign idx_o       = idx_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    len_d   = len_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          len_d   = len_i;
          idx_d   = '0;
          state_d = (len_i == '0) ? ST_DONE : ST_REQ;
        end
      end
      ST_REQ: begin
        if (req_ready_i) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rsp_valid_i) begin
          if (last_o) begin
            state_d = ST_DONE;
          end else begin
            idx_d   = idx_q + LEN_W'(1);
            state_d = ST_REQ;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      len_q   <= len_d;
    end
  end

endmodule

// File: rtl/svl_sequencer.sv
module svl_sequencer #(
  parameter int RW      = 5,
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int MAX_LEN = 8,
  parameter int NUM_OFS = 2,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [RW-1:0]         start_dst,
  input  logic [RW-1:0]         start_base,
  input  logic [AW-1:0]         start_imm,
  input  logic [LEN_W-1:0]      start_len,
  input  logic [NUM_OFS-1:0]    ofs_en,
  input  logic [NUM_OFS*RW-1:0] ofs_reg,
  input  logic [NUM_OFS*AW-1:0] ofs_amt,
  input  logic [NUM_OFS-1:0]    ofs_imm_stride,
  output logic [RW-1:0]         rd_addr,
  input  logic [DW-1:0]         rd_data,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [AW-1:0]         mem_req_addr,
  input  logic                  mem_rsp_valid,
  input  logic [DW-1:0]         mem_rsp_data,
  output logic                  wr_en,
  output logic [RW-1:0]         wr_addr,
  output logic [DW-1:0]         wr_data,
  output logic                  busy,
  output logic                  done
);

  // named internal events, visible to the bound checker
  logic             start_accept;
  logic             elem_last;
  logic [LEN_W-1:0] elem_idx;

  logic [AW-1:0]    ofs_sel, stride_sel;
  logic [AW-1:0]    ofs_q, stride_q;
  logic [RW-1:0]    dst_q, base_q;
  logic [AW-1:0]    base_val;

  svl_ofs_lookup #(
    .NUM_OFS(NUM_OFS), .RW(RW), .AW(AW)
  ) u_lookup (
    .base_reg_i       (start_base),
    .imm_i            (start_imm),
    .ent_en_i         (ofs_en),
    .ent_reg_i        (ofs_reg),
    .ent_amt_i        (ofs_amt),
    .ent_imm_stride_i (ofs_imm_stride),
    .ofs_o            (ofs_sel),
    .stride_o         (stride_sel)
  );

  svl_elem_ctrl #(
    .LEN_W(LEN_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .len_i       (start_len),
    .req_ready_i (mem_req_ready),
    .rsp_valid_i (mem_rsp_valid),
    .accept_o    (start_accept),
    .idx_o       (elem_idx),
    .req_valid_o (mem_req_valid),
    .wr_fire_o   (wr_en),
    .last_o      (elem_last),
    .busy_o      (busy),
    .done_o      (done)
  );

  // operation context, captured once per accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q    <= '0;
      base_q   <= '0;
      ofs_q    <= '0;
      stride_q <= AW'(1);
    end else if (start_accept) begin
      dst_q    <= start_dst;
      base_q   <= start_base;
      ofs_q    <= ofs_sel;
      stride_q <= stride_sel;
    end
  end

  assign rd_addr  = RW'(svl_pkg::svl_reg_step(64'(base_q), 64'(elem_idx)));
  assign wr_addr  = RW'(svl_pkg::svl_reg_step(64'(dst_q), 64'(elem_idx)));
  assign wr_data  = mem_rsp_data;
  assign base_val = AW'(rd_data);

  svl_addr_gen #(
    .AW(AW), .LEN_W(LEN_W)
  ) u_addr (
    .ofs_i      (ofs_q),
    .stride_i   (stride_q),
    .idx_i      (elem_idx),
    .base_val_i (base_val),
    .addr_o     (mem_req_addr)
  );

endmodule

// File: rtl/svl_sequencer_chk.sv
module svl_sequencer_chk #(
  parameter int LEN_W = 4,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_accept,
  input logic             elem_last,
  input logic [LEN_W-1:0] start_len,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [AW-1:0]    mem_req_addr,
  input logic             mem_rsp_valid,
  input logic             wr_en,
  input logic             busy,
  input logic             done
);

  logic             outstanding;
  logic [LEN_W-1:0] wcnt;
  logic [LEN_W-1:0] len_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
      wcnt        <= '0;
      len_cap     <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
      else if (wr_en)                     outstanding <= 1'b0;
      if (start_accept) begin
        wcnt    <= '0;
        len_cap <= start_len;
      end else if (wr_en) begin
        wcnt    <= wcnt + LEN_W'(1);
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (!busy && !done && !mem_req_valid && !wr_en);
    end
  end

  assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !outstanding);

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_write_has_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (mem_rsp_valid && outstanding));

  assert_write_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wcnt == len_cap));

  assert_last_then_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && elem_last) |=> done);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_accept && (start_len == '0)) |=> (done && !mem_req_valid));

  assert_no_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_accept);

endmodule

bind svl_sequencer svl_sequencer_chk #(
  .LEN_W(LEN_W), .AW(AW)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_accept  (start_accept),
  .elem_last     (elem_last),
  .start_len     (start_len),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .wr_en         (wr_en),
  .busy          (busy),
  .done          (done)
);

// File: tb/svl_sequencer_tb.sv
`timescale 1ns/1ps
module svl_sequencer_tb;

  localparam int RW = 5, AW = 32, DW = 32, MAX_LEN = 8, NUM_OFS = 2;
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int NREG = 1 << RW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [RW-1:0] start_dst = '0, start_base = '0;
  logic [AW-1:0] start_imm = '0;
  logic [LEN_W-1:0] start_len = '0;
  logic [NUM_OFS-1:0] ofs_en = '0, ofs_imm_stride = '0;
  logic [NUM_OFS*RW-1:0] ofs_reg = '0;
  logic [NUM_OFS*AW-1:0] ofs_amt = '0;
  logic [RW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_rsp_data;
  logic wr_en, busy, done;
  logic [RW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  always #2 clk = ~clk;

  svl_sequencer #(.RW(RW), .AW(AW), .DW(DW), .MAX_LEN(MAX_LEN), .NUM_OFS(NUM_OFS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_dst(start_dst),
    .start_base(start_base), .start_imm(start_imm), .start_len(start_len),
    .ofs_en(ofs_en), .ofs_reg(ofs_reg), .ofs_amt(ofs_amt),
    .ofs_imm_stride(ofs_imm_stride), .rd_addr(rd_addr), .rd_data(rd_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .done(done));

  // register file model: static contents
  function automatic logic [31:0] reg_val(int k);
    return 32'h100 + 32'(k % NREG) * 32'h10;
  endfunction
  assign rd_data = reg_val(int'(rd_addr));

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return (a * 32'h0000_9E37) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] exp_addr(int ofs, int str, int base, int i);
    logic [31:0] b, prod;
    b    = reg_val(base + i);
    prod = 32'(ofs) * 32'(i);
    return (prod + b) * 32'(str);
  endfunction

  // memory model: two-cycle response, optional ready stalls
  logic stall = 1'b0;
  logic ready_q, p0, p1;
  logic [31:0] a0, a1;
  int req_cnt, wcnt;
  logic [31:0] reqlog [64];
  logic [RW-1:0] wlog_a [64];
  logic [31:0] wlog_d [64];

  assign mem_req_ready = ready_q;
  assign mem_rsp_valid = p1;
  assign mem_rsp_data  = mem_word(a1);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0; p0 <= 1'b0; p1 <= 1'b0; a0 <= '0; a1 <= '0;
      req_cnt <= 0; wcnt <= 0;
    end else begin
      ready_q <= stall ? ~ready_q : 1'b1;
      p0 <= mem_req_valid && mem_req_ready;
      a0 <= mem_req_addr;
      p1 <= p0;
      a1 <= a0;
      if (mem_req_valid && mem_req_ready) begin
        if (req_cnt < 64) reqlog[req_cnt] <= mem_req_addr;
        req_cnt <= req_cnt + 1;
      end
      if (wr_en) begin
        if (wcnt < 64) begin
          wlog_a[wcnt] <= wr_addr;
          wlog_d[wcnt] <= wr_data;
        end
        wcnt <= wcnt + 1;
      end
    end
  end

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic set_tab(int e0en, int e0reg, int e0amt, int e0md,
                         int e1en, int e1reg, int e1amt, int e1md);
    ofs_en         = {1'(e1en), 1'(e0en)};
    ofs_reg        = {RW'(e1reg), RW'(e0reg)};
    ofs_amt        = {AW'(e1amt), AW'(e0amt)};
    ofs_imm_stride = {1'(e1md), 1'(e0md)};
  endtask

  task automatic pulse_start(int dst, int base, int len, int imm);
    start_dst = RW'(dst); start_base = RW'(base);
    start_len = LEN_W'(len); start_imm = AW'(imm);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int c = 0; c < 400; c++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic verify(int w0, int r0, int dst, int base, int len,
                        int ofs, int str, string tag);
    chk(wcnt - w0 == len, "R6", {tag, " write count"}, 32'(wcnt - w0), 32'(len));
    chk(req_cnt - r0 == len, "R7", {tag, " request count"}, 32'(req_cnt - r0), 32'(len));
    for (int i = 0; i < len; i++) begin
      logic [31:0] ea;
      ea = exp_addr(ofs, str, base, i);
      chk(reqlog[r0+i] == ea, "R5", {tag, " request address"}, reqlog[r0+i], ea);
      chk(wlog_a[w0+i] == RW'(dst + i), "R6", {tag, " write index"},
          32'(wlog_a[w0+i]), 32'(RW'(dst + i)));
      chk(wlog_d[w0+i] == mem_word(ea), "R6", {tag, " write data"},
          wlog_d[w0+i], mem_word(ea));
    end
  endtask

  // stimulus table with expected offset and stride
  localparam int NV = 7;
  localparam int V_DST  [NV] = '{ 8, 12, 16, 20, 24, 30,  1};
  localparam int V_BASE [NV] = '{ 2,  2,  3,  4,  6, 29,  0};
  localparam int V_LEN  [NV] = '{ 4,  3,  4,  2,  3,  4,  8};
  localparam int V_IMM  [NV] = '{ 3,  3,  3,  6,  4,  2,  2};
  localparam int V_E0EN [NV] = '{ 0,  1,  1,  1,  1,  0,  1};
  localparam int V_E0RG [NV] = '{ 2,  2,  3,  4,  1, 29,  0};
  localparam int V_E0AM [NV] = '{ 9,  5,  5,  7, 11,  3,  1};
  localparam int V_E0MD [NV] = '{ 1,  0,  1,  0,  1,  1,  1};
  localparam int V_E1EN [NV] = '{ 0,  0,  0,  1,  1,  0,  0};
  localparam int V_E1RG [NV] = '{ 0,  0,  0,  4,  6,  0,  0};
  localparam int V_E1AM [NV] = '{ 0,  0,  0,  9,  2,  0,  0};
  localparam int V_E1MD [NV] = '{ 0,  0,  0,  1,  1,  0,  0};
  localparam int V_STAL [NV] = '{ 0,  1,  0,  0,  1,  1,  0};
  localparam int V_XOFS [NV] = '{ 0,  5,  5,  7,  2,  0,  1};
  localparam int V_XSTR [NV] = '{ 1,  1,  3,  1,  4,  1,  2};

  initial begin : watchdog
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    bit seen;
    int w0, r0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req_valid && !wr_en, "R1", "outputs in reset",
        {28'd0, busy, done, mem_req_valid, wr_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req_valid && !wr_en, "R1", "outputs after reset",
        {28'd0, busy, done, mem_req_valid, wr_en}, 32'd0);

    // table walk: R2 R3 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      stall = 1'(V_STAL[v]);
      set_tab(V_E0EN[v], V_E0RG[v], V_E0AM[v], V_E0MD[v],
              V_E1EN[v], V_E1RG[v], V_E1AM[v], V_E1MD[v]);
      w0 = wcnt; r0 = req_cnt;
      pulse_start(V_DST[v], V_BASE[v], V_LEN[v], V_IMM[v]);
      chk(busy == 1'b1, "R8", $sformatf("vec%0d busy after start", v), 32'(busy), 32'd1);
      wait_done(seen);
      chk(seen, "R8", $sformatf("vec%0d done seen", v), 32'(seen), 32'd1);
      chk(busy == 1'b1, "R8", $sformatf("vec%0d busy with done", v), 32'(busy), 32'd1);
      @(negedge clk);
      chk(!done && !busy, "R8", $sformatf("vec%0d done one cycle", v),
          {30'd0, done, busy}, 32'd0);
      verify(w0, r0, V_DST[v], V_BASE[v], V_LEN[v], V_XOFS[v], V_XSTR[v],
             $sformatf("vec%0d", v));
      @(negedge clk);
    end

    // R9: zero length
    stall = 1'b0;
    set_tab(1, 7, 4, 1, 0, 0, 0, 0);
    w0 = wcnt; r0 = req_cnt;
    pulse_start(5, 7, 0, 3);
    chk(done == 1'b1, "R9", "zero length done next cycle", 32'(done), 32'd1);
    @(negedge clk);
    chk(!done && !busy, "R9", "zero length back to idle", {30'd0, done, busy}, 32'd0);
    repeat (4) @(negedge clk);
    chk(req_cnt == r0 && wcnt == w0, "R9", "zero length no traffic",
        32'(req_cnt - r0 + wcnt - w0), 32'd0);

    // R10: start while busy ignored
    stall = 1'b1;
    set_tab(0, 0, 0, 0, 0, 0, 0, 0);
    w0 = wcnt; r0 = req_cnt;
    pulse_start(10, 5, 4, 1);
    @(negedge clk);
    @(negedge clk);
    set_tab(1, 9, 6, 1, 0, 0, 0, 0);
    pulse_start(0, 9, 1, 5);
    wait_done(seen);
    chk(seen, "R10", "first op completes", 32'(seen), 32'd1);
    @(negedge clk);
    verify(w0, r0, 10, 5, 4, 0, 1, "R10 busy start");
    repeat (8) @(negedge clk);
    chk(wcnt - w0 == 4 && !busy, "R10", "no op after ignored start",
        32'(wcnt - w0), 32'd4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule